// File: doc/BRIEF.md
# DMA Channel Security Gate

This block sits in front of the per-channel register windows of a multi-channel DMA engine. It records a security level for each channel and checks every register access aimed at a channel against the Secure and Privileged attributes of the requester. A requester may touch a channel only when its own level ranks at least as high as the channel's level. The ranking from highest to lowest is Secure+Privileged, Secure+Unprivileged, Non-secure+Privileged, Non-secure+Unprivileged. This covers programming, trigger and abort commands, busy status, and interrupt enable and acknowledge.

Each channel has a security configuration word. Any requester may read it. Only a Secure+Privileged requester may write it, and only while the channel is unlocked. The lock arms by itself on the first granted write into the channel's register window and clears only on reset. Group trigger and group abort writes are filtered bit by bit, so a requester can start or stop only the channels it is cleared for.

Every access gets a response one cycle later that carries a deny flag and the read data. The block also drives per-channel trigger and abort pulses, levels, lock flags and interrupt lines towards the DMA datapath.

Top module: `dma_sec_gate`

## Requirements
- R1: After reset every channel's level is Secure+Privileged (`lvl_o` all ones), every lock is clear, and `trig_o`, `abort_o`, `irq_o`, `resp_o` and `err_o` are low.
- R2: Address map: `addr_i[7:6]`=0 selects a channel window, with the channel in `addr_i[5:2]` and the register in `addr_i[1:0]` (0 program word, 1 command/status, 2 interrupt enable, 3 interrupt acknowledge/pending). `addr_i[7:6]`=1 selects the security word of channel `addr_i[3:0]`. `addr_i[7:6]`=2 is the group command (`addr_i[0]`=0 trigger, 1 abort). A level is encoded {S,P} and ranks S+P=3, S+U=2, NS+P=1, NS+U=0. A channel-window access is granted only when the requester's rank is at least the channel's rank.
- R3: A denied read returns zero data. A denied write changes no state and raises no trigger or abort pulse. Both raise `err_o`.
- R4: A security word read is granted for every requester level. It returns the level in bits [1:0] and the lock flag in bit 2.
- R5: A security word write is granted only for a Secure+Privileged requester on an unlocked channel, and it loads `wdata_i[1:0]` as the new level. Any other such write is denied and leaves the level unchanged.
- R6: A granted write into a channel's window sets that channel's lock, which persists until reset. A security word write does not set it.
- R7: A group trigger or abort write is always granted. It applies `wdata_i` bit n to channel n only if the requester satisfies channel n's level, and masked bits have no effect.
- R8: For each cycle with `req_i` high, `resp_o` is high exactly one cycle later, together with `err_o` and `rdata_o`. Writes return zero data.
- R9: Command register: write bit 0 triggers and bit 1 aborts, and abort wins when both are set. The `trig_o`/`abort_o` pulse lasts one cycle and comes with the response. Reading the register returns the busy flag in bit 0. Busy is set by a trigger and cleared by an abort or by `done_i`.
- R10: A `done_i` pulse on a busy channel with its interrupt enable set sets that channel's pending flag. `irq_o` is pending AND enable. Writing 1 to bit 0 of the acknowledge register clears pending, and reading it returns pending. A `done_i` pulse with the enable clear sets nothing.
- R11: Accesses to area 3, or to a channel index at or above `NUM_CH`, are denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access valid this cycle |
| we_i | input | 1 | Access is a write |
| addr_i | input | 8 | Register address |
| wdata_i | input | DW | Write data |
| sec_i | input | 1 | Requester is Secure |
| priv_i | input | 1 | Requester is Privileged |
| done_i | input | NUM_CH | Per-channel transfer completion from the datapath |
| resp_o | output | 1 | Response valid, one cycle after the access |
| err_o | output | 1 | Access was denied |
| rdata_o | output | DW | Read data, zero if denied or written |
| lock_o | output | NUM_CH | Per-channel security word lock |
| lvl_o | output | 2*NUM_CH | Per-channel level {S,P}, channel n at bits [2n+1:2n] |
| trig_o | output | NUM_CH | One-cycle channel trigger pulse |
| abort_o | output | NUM_CH | One-cycle channel abort pulse |
| irq_o | output | NUM_CH | Per-channel interrupt line |

## Verification
The assertions assume that reset is held from time zero and that the inputs settle well before each rising edge. They also assume that `req_i` marks one access per cycle and that `done_i` is meaningful only for a channel the stimulus has triggered. The bench drives every input on the falling edge and always leaves an idle cycle between accesses. It pulses `done_i` for a single cycle, and only on channels that are busy, or on a busy channel whose interrupt is deliberately left disabled. This keeps the properties about response timing, level stability under lock and trigger masking within the traffic they were written for.

// File: rtl/dma_sec_pkg.sv
package dma_sec_pkg;

  localparam int ADDR_W   = 8;
  localparam int CH_IDX_W = 4;

  // level encoding {secure, privileged}
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_SP = 2'b11;

  typedef enum logic [1:0] {
    AREA_CHAN = 2'd0,
    AREA_SEC  = 2'd1,
    AREA_GLOB = 2'd2,
    AREA_NONE = 2'd3
  } area_e;

  typedef enum logic [1:0] {
    CREG_CTRL = 2'd0,
    CREG_CMD  = 2'd1,
    CREG_IEN  = 2'd2,
    CREG_IACK = 2'd3
  } creg_e;

  typedef struct packed {
    area_e                area;
    logic [CH_IDX_W-1:0]  ch;
    creg_e                creg;
    logic                 glob_abort;
  } dec_t;

  // Secure outranks Privileged: S+P > S+U > NS+P > NS+U
  function automatic logic [1:0] lvl_rank(lvl_t l);
    case (l)
      2'b11:   return 2'd3;
      2'b10:   return 2'd2;
      2'b01:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic lvl_covers(lvl_t req, lvl_t need);
    return lvl_rank(req) >= lvl_rank(need);
  endfunction

endpackage

// File: rtl/dma_sec_decode.sv
module dma_sec_decode
  import dma_sec_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o,
  output logic              ch_ok_o
);

  logic [CH_IDX_W-1:0] ch_idx;
  area_e               area;

  always_comb begin
    area    = area_e'(addr_i[7:6]);
    ch_idx  = (area == AREA_SEC) ? addr_i[3:0] : addr_i[5:2];
    dec_o.area       = area;
    dec_o.ch         = ch_idx;
    dec_o.creg       = creg_e'(addr_i[1:0]);
    dec_o.glob_abort = addr_i[0];
    ch_ok_o = (32'(ch_idx) < 32'(NUM_CH));
  end

endmodule

// File: rtl/dma_sec_chan.sv
module dma_sec_chan
  import dma_sec_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_i,
  input  logic          we_i,
  input  creg_e         creg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sec_wr_i,
  input  logic          mtrig_i,
  input  logic          mabort_i,
  input  logic          done_i,
  output lvl_t          lvl_o,
  output logic          lock_o,
  output logic [DW-1:0] ctrl_o,
  output logic          busy_o,
  output logic          ien_o,
  output logic          pend_o,
  output logic          trig_o,
  output logic          abort_o,
  output logic          irq_o
);

  lvl_t          lvl_q;
  logic          lock_q, busy_q, ien_q, pend_q, trig_q, abort_q;
  logic [DW-1:0] ctrl_q;

  logic wr, cmd_wr, trig_req, abort_req, ack_req;

  always_comb begin
    wr        = acc_i && we_i;
    cmd_wr    = wr && (creg_i == CREG_CMD);
    abort_req = (cmd_wr && wdata_i[1]) || mabort_i;
    trig_req  = (cmd_wr && wdata_i[0]) || mtrig_i;
    ack_req   = wr && (creg_i == CREG_IACK) && wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= LVL_SP;
      lock_q  <= 1'b0;
      ctrl_q  <= '0;
      busy_q  <= 1'b0;
      ien_q   <= 1'b0;
      pend_q  <= 1'b0;
      trig_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      trig_q  <= trig_req && !abort_req;
      abort_q <= abort_req;
      if (sec_wr_i) lvl_q <= wdata_i[1:0];
      if (wr) lock_q <= 1'b1;
      if (wr && creg_i == CREG_CTRL) ctrl_q <= wdata_i;
      if (wr && creg_i == CREG_IEN)  ien_q  <= wdata_i[0];
      if (abort_req)     busy_q <= 1'b0;
      else if (trig_req) busy_q <= 1'b1;
      else if (done_i)   busy_q <= 1'b0;
      if (done_i && busy_q && ien_q) pend_q <= 1'b1;
      else if (ack_req)              pend_q <= 1'b0;
    end
  end

  assign lvl_o   = lvl_q;
  assign lock_o  = lock_q;
  assign ctrl_o  = ctrl_q;
  assign busy_o  = busy_q;
  assign ien_o   = ien_q;
  assign pend_o  = pend_q;
  assign trig_o  = trig_q;
  assign abort_o = abort_q;
  assign irq_o   = pend_q && ien_q;

endmodule

// File: rtl/dma_sec_gate.sv
module dma_sec_gate
  import dma_sec_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [7:0]          addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                sec_i,
  input  logic                priv_i,
  input  logic [NUM_CH-1:0]   done_i,
  output logic                resp_o,
  output logic                err_o,
  output logic [DW-1:0]       rdata_o,
  output logic [NUM_CH-1:0]   lock_o,
  output logic [2*NUM_CH-1:0] lvl_o,
  output logic [NUM_CH-1:0]   trig_o,
  output logic [NUM_CH-1:0]   abort_o,
  output logic [NUM_CH-1:0]   irq_o
);

  // named internal events, also observed by the checker
  lvl_t                      req_lvl;
  dec_t                      dec;
  logic                      ch_ok;
  logic                      allow, acc_ok, acc_bad;
  logic [NUM_CH-1:0]         sat_mask;
  logic [NUM_CH-1:0]         mtrig, mabort;

  lvl_t  [NUM_CH-1:0]        lvl_a;
  logic  [NUM_CH-1:0]        lock_a, busy_a, ien_a, pend_a;
  logic  [NUM_CH-1:0][DW-1:0] ctrl_a;

  lvl_t          sel_lvl;
  logic          sel_lock, sel_busy, sel_ien, sel_pend;
  logic [DW-1:0] sel_ctrl, rd_word;

  logic          resp_q, err_q;
  logic [DW-1:0] rdata_q;

  assign req_lvl = {sec_i, priv_i};

  dma_sec_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i  (addr_i),
    .dec_o   (dec),
    .ch_ok_o (ch_ok)
  );

  // selected channel view
  always_comb begin
    sel_lvl  = LVL_SP;
    sel_lock = 1'b0;
    sel_busy = 1'b0;
    sel_ien  = 1'b0;
    sel_pend = 1'b0;
    sel_ctrl = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (dec.ch == CH_IDX_W'(i)) begin
        sel_lvl  = lvl_a[i];
        sel_lock = lock_a[i];
        sel_busy = busy_a[i];
        sel_ien  = ien_a[i];
        sel_pend = pend_a[i];
        sel_ctrl = ctrl_a[i];
      end
    end
  end

  // grant decision
  always_comb begin
    case (dec.area)
      AREA_CHAN: allow = ch_ok && lvl_covers(req_lvl, sel_lvl);
      AREA_SEC:  allow = ch_ok && (!we_i || (req_lvl == LVL_SP && !sel_lock));
      AREA_GLOB: allow = 1'b1;
      default:   allow = 1'b0;
    endcase
    acc_ok  = req_i && allow;
    acc_bad = req_i && !allow;
  end

  // read data
  always_comb begin
    rd_word = '0;
    case (dec.area)
      AREA_CHAN: begin
        case (dec.creg)
          CREG_CTRL: rd_word = sel_ctrl;
          CREG_CMD:  rd_word = DW'(sel_busy);
          CREG_IEN:  rd_word = DW'(sel_ien);
          default:   rd_word = DW'(sel_pend);
        endcase
      end
      AREA_SEC: rd_word = DW'({sel_lock, sel_lvl});
      default:  rd_word = '0;
    endcase
  end

  // group command masking
  always_comb begin
    mtrig  = '0;
    mabort = '0;
    if (acc_ok && we_i && dec.area == AREA_GLOB) begin
      if (dec.glob_abort) mabort = wdata_i[NUM_CH-1:0] & sat_mask;
      else                mtrig  = wdata_i[NUM_CH-1:0] & sat_mask;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit_chan, hit_sec;

    assign sat_mask[g] = lvl_covers(req_lvl, lvl_a[g]);
    assign hit_chan    = acc_ok && dec.area == AREA_CHAN && dec.ch == CH_IDX_W'(g);
    assign hit_sec     = acc_ok && we_i && dec.area == AREA_SEC && dec.ch == CH_IDX_W'(g);

    dma_sec_chan #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_i    (hit_chan),
      .we_i     (we_i),
      .creg_i   (dec.creg),
      .wdata_i  (wdata_i),
      .sec_wr_i (hit_sec),
      .mtrig_i  (mtrig[g]),
      .mabort_i (mabort[g]),
      .done_i   (done_i[g]),
      .lvl_o    (lvl_a[g]),
      .lock_o   (lock_a[g]),
      .ctrl_o   (ctrl_a[g]),
      .busy_o   (busy_a[g]),
      .ien_o    (ien_a[g]),
      .pend_o   (pend_a[g]),
      .trig_o   (trig_o[g]),
      .abort_o  (abort_o[g]),
      .irq_o    (irq_o[g])
    );

    assign lvl_o[2*g +: 2] = lvl_a[g];
  end

  // registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      resp_q  <= req_i;
      err_q   <= acc_bad;
      rdata_q <= (acc_ok && !we_i) ? rd_word : '0;
    end
  end

  assign resp_o  = resp_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
  assign lock_o  = lock_a;

endmodule

// File: rtl/dma_sec_gate_chk.sv
module dma_sec_gate_chk #(
  parameter int NUM_CH = 4,
  parameter int DW     = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_i,
  input logic                we_i,
  input logic [7:0]          addr_i,
  input logic                sec_i,
  input logic                priv_i,
  input logic                resp_o,
  input logic                err_o,
  input logic [DW-1:0]       rdata_o,
  input logic [NUM_CH-1:0]   lock_o,
  input logic [2*NUM_CH-1:0] lvl_o,
  input logic [NUM_CH-1:0]   trig_o,
  input logic [NUM_CH-1:0]   abort_o,
  input logic [NUM_CH-1:0]   sat_mask
);

  logic [2*NUM_CH-1:0] lock2;
  for (genvar g = 0; g < NUM_CH; g++) begin : g_l2
    assign lock2[2*g +: 2] = {2{lock_o[g]}};
  end

  assert_resp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> resp_o);
  assert_resp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !resp_o);
  assert_err_has_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> resp_o);
  assert_denied_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (rdata_o == '0));
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_o & $past(lock_o)) == $past(lock_o)));
  assert_level_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((lvl_o ^ $past(lvl_o)) & $past(lock2)) == '0));
  assert_level_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lvl_o == $past(lvl_o)) || $past(req_i && we_i && sec_i && priv_i)));
  assert_sp_chan_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && sec_i && priv_i && addr_i[7:6] == 2'b00 && (32'(addr_i[5:2]) < 32'(NUM_CH)))
      |=> !err_o);
  assert_trig_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((trig_o & ~$past(sat_mask)) == '0));
  assert_abort_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((abort_o & ~$past(sat_mask)) == '0));
  assert_trig_abort_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o & abort_o) == '0);

endmodule

bind dma_sec_gate dma_sec_gate_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .sec_i    (sec_i),
  .priv_i   (priv_i),
  .resp_o   (resp_o),
  .err_o    (err_o),
  .rdata_o  (rdata_o),
  .lock_o   (lock_o),
  .lvl_o    (lvl_o),
  .trig_o   (trig_o),
  .abort_o  (abort_o),
  .sat_mask (sat_mask)
);

// File: tb/dma_sec_gate_test.sv
`timescale 1ns/1ps
module dma_sec_gate_test;

  localparam int NCH = 4;
  localparam int W   = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_i = 1'b0, we_i = 1'b0, sec_i = 1'b0, priv_i = 1'b0;
  logic [7:0]     addr_i = '0;
  logic [W-1:0]   wdata_i = '0;
  logic [NCH-1:0] done_i = '0;
  logic           resp_o, err_o;
  logic [W-1:0]   rdata_o;
  logic [NCH-1:0] lock_o, trig_o, abort_o, irq_o;
  logic [2*NCH-1:0] lvl_o;

  int checks = 0;
  int errors = 0;

  logic        q_err[$];
  logic [31:0] q_rd[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  dma_sec_gate #(.NUM_CH(NCH), .DW(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .sec_i(sec_i), .priv_i(priv_i), .done_i(done_i),
    .resp_o(resp_o), .err_o(err_o), .rdata_o(rdata_o), .lock_o(lock_o),
    .lvl_o(lvl_o), .trig_o(trig_o), .abort_o(abort_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] ca(int ch, int r);
    return 8'(ch * 4 + r);
  endfunction
  function automatic logic [7:0] sa(int ch);
    return 8'(8'h40 + ch);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called on a falling edge, returns on the falling edge where the response is visible
  task automatic access(logic we, logic [7:0] a, logic [31:0] wd, logic s, logic p,
                        logic exp_err, logic [31:0] exp_rd, string tag);
    q_err.push_back(exp_err);
    q_rd.push_back(exp_rd);
    q_tag.push_back(tag);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = wd; sec_i = s; priv_i = p;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (resp_o === 1'b1) begin
      if (q_err.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected response actual=1 expected=0");
      end else begin
        logic        e_err;
        logic [31:0] e_rd;
        string       t;
        e_err = q_err.pop_front();
        e_rd  = q_rd.pop_front();
        t     = q_tag.pop_front();
        chk({t, " err"}, 32'(err_o), 32'(e_err));
        chk({t, " rdata"}, rdata_o, e_rd);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 lvl", 32'(lvl_o), 32'hFF);
    chk("R1 lock", 32'(lock_o), 0);
    chk("R1 trig", 32'(trig_o), 0);
    chk("R1 abort", 32'(abort_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 resp", 32'(resp_o), 0);

    // R4 / R5 security words
    access(0, sa(0), 0, 0, 0, 0, 32'h3, "R4 read sec0 by NS+U");
    idle();
    access(1, sa(1), 1, 1, 0, 1, 0, "R5 S+U sec write denied");
    idle();
    access(0, sa(1), 0, 0, 0, 0, 32'h3, "R5 level kept");
    idle();
    access(1, sa(1), 1, 1, 1, 0, 0, "R5 sec1=NS+P");
    idle();
    access(1, sa(2), 2, 1, 1, 0, 0, "R5 sec2=S+U");
    idle();
    access(1, sa(3), 0, 1, 1, 0, 0, "R5 sec3=NS+U");
    idle();
    chk("R5 levels", 32'(lvl_o), 32'h27);
    chk("R6 no lock from sec write", 32'(lock_o), 0);

    // R2 / R3 rank checks
    access(0, ca(2, 0), 0, 0, 1, 1, 0, "R2 NS+P on S+U chan denied R3");
    idle();
    access(0, ca(1, 0), 0, 0, 0, 1, 0, "R2 NS+U on NS+P chan denied");
    idle();
    access(1, ca(1, 0), 32'h1234, 0, 1, 0, 0, "R2 NS+P programs chan1");
    idle();
    access(0, ca(1, 0), 0, 1, 0, 0, 32'h1234, "R2 S+U outranks NS+P");
    idle();
    access(1, ca(1, 0), 32'hDEAD, 0, 0, 1, 0, "R3 NS+U write denied");
    idle();
    access(0, ca(1, 0), 0, 1, 1, 0, 32'h1234, "R3 program word unchanged");
    idle();
    access(1, ca(3, 0), 32'h55, 0, 0, 0, 0, "R2 NS+U programs chan3");
    idle();
    chk("R6 locks", 32'(lock_o), 32'hA);

    // R6 lock blocks security writes
    access(1, sa(1), 0, 1, 1, 1, 0, "R6 locked sec write denied");
    idle();
    access(0, sa(1), 0, 0, 0, 0, 32'h5, "R4 sec word shows lock");
    idle();
    chk("R6 levels kept", 32'(lvl_o), 32'h27);

    // R7 group commands
    access(1, 8'h80, 32'hF, 0, 1, 0, 0, "R7 group trig NS+P");
    chk("R7 trig mask NS+P", 32'(trig_o), 32'hA);
    idle();
    access(1, 8'h80, 32'hF, 1, 0, 0, 0, "R7 group trig S+U");
    chk("R7 trig mask S+U", 32'(trig_o), 32'hE);
    idle();
    access(1, 8'h81, 32'hF, 0, 0, 0, 0, "R7 group abort NS+U");
    chk("R7 abort mask", 32'(abort_o), 32'h8);
    chk("R7 no trig on abort", 32'(trig_o), 0);
    idle();
    access(0, ca(0, 1), 0, 1, 1, 0, 0, "R7 chan0 not triggered");
    idle();

    // R9 command register
    access(0, ca(3, 1), 0, 0, 0, 0, 0, "R9 chan3 idle");
    idle();
    access(1, ca(3, 1), 1, 0, 0, 0, 0, "R9 trigger");
    chk("R9 trig pulse", 32'(trig_o), 32'h8);
    idle();
    chk("R9 trig one cycle", 32'(trig_o), 0);
    access(0, ca(3, 1), 0, 0, 0, 0, 1, "R9 busy");
    idle();
    access(1, ca(3, 1), 3, 0, 0, 0, 0, "R9 abort wins");
    chk("R9 abort pulse", 32'(abort_o), 32'h8);
    chk("R9 no trig", 32'(trig_o), 0);
    idle();
    access(0, ca(3, 1), 0, 0, 0, 0, 0, "R9 busy cleared");
    idle();

    // R10 interrupts
    access(1, ca(3, 2), 1, 0, 0, 0, 0, "R10 enable");
    idle();
    access(0, ca(3, 2), 0, 0, 0, 0, 1, "R10 enable readback");
    idle();
    access(1, ca(3, 1), 1, 0, 0, 0, 0, "R10 start");
    done_i = 4'b1000;
    @(negedge clk);
    done_i = '0;
    chk("R10 irq set", 32'(irq_o), 32'h8);
    access(0, ca(3, 3), 0, 0, 0, 0, 1, "R10 pending read");
    idle();
    access(0, ca(3, 1), 0, 0, 0, 0, 0, "R9 done clears busy");
    idle();
    access(1, ca(3, 3), 1, 0, 0, 0, 0, "R10 ack");
    chk("R10 irq cleared", 32'(irq_o), 0);
    idle();
    access(0, ca(3, 3), 0, 0, 0, 0, 0, "R10 pending cleared");
    idle();
    done_i = 4'b0100;
    @(negedge clk);
    done_i = '0;
    chk("R10 no irq when disabled", 32'(irq_o), 0);
    access(0, ca(2, 3), 0, 1, 1, 0, 0, "R10 no pending when disabled");
    idle();

    // R11 unmapped
    access(0, 8'hC0, 0, 1, 1, 1, 0, "R11 area3 read");
    idle();
    access(1, 8'hC3, 1, 1, 1, 1, 0, "R11 area3 write");
    idle();
    access(0, ca(5, 0), 0, 1, 1, 1, 0, "R11 chan5 window");
    idle();
    access(0, sa(7), 0, 1, 1, 1, 0, "R11 sec word chan7");
    idle();
    chk("R8 idle no resp", 32'(resp_o), 0);
    chk("R8 queue drained", 32'(q_err.size()), 0);

    // R6 lock clears only on reset
    chk("R6 locks before reset", 32'(lock_o), 32'hA);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 lock cleared by reset", 32'(lock_o), 0);
    chk("R1 level after reset", 32'(lvl_o), 32'hFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule